// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block sets the length of one external memory bus cycle for a single chip-select region. Two 4-bit configuration codes are supplied, one used for reads and one for writes. When an idle sequencer accepts a request, it takes the code that matches the access direction and holds it for the whole cycle. It then either runs a fixed number of bus states or, in handshake mode, runs a six-state minimum and stretches the cycle with an external active-low wait pin. One bus state is one clock period.

While the cycle runs, the block raises `busy`. It pulses `done` in the final state. Code `0000` is reserved: it runs as the default three-state cycle and sets a sticky error flag. While the region is served by another controller, `bypass` stops the sequencer from starting a cycle, and the block answers the request with a one-clock not-serviced pulse. The wait pin passes through a synchronizer before it is used. The decision point is moved forward by the synchronizer's latency, so the pin is still looked at around the sixth state.

Top module: `busWaitSeq`

## Requirements
- R1: While `rstN` is low, and on the first clock after it is released, `busy`, `done`, `notServiced` and `cfgError` are all low.
- R2: A read (`reqWrite`=0) uses `rdCode` and a write (`reqWrite`=1) uses `wrCode`. The code is the one present at the accepting clock edge.
- R3: Fixed codes give these total state counts: 0001→2, 0010→3, 0101→4, 0110→5, 0111→6, 1000→7, 1001→8, 1010→9, 1011→10, 1100→11, 1101→12, 1110→14, 1111→18, 0100→22.
- R4: After the accepting edge, `busy` is high for exactly the cycle's state count. `done` is high for exactly one clock, which is the last clock in which `busy` is high.
- R5: Code 0000 runs a three-state cycle and sets `cfgError`. `cfgError` then stays high until reset.
- R6: A change to `rdCode` or `wrCode` while a cycle runs has no effect on that cycle's length.
- R7: A request is accepted only on an edge where `busy` is low. With `reqValid` held high, a two-state cycle is followed by exactly one idle clock before the next cycle starts.
- R8: When `reqValid` and `bypass` are both high on an idle edge, no cycle starts. `notServiced` is high for the one following clock.
- R9: Code 0011 selects handshake mode. Number the states 1, 2, 3… from the accepting edge. The final state is the first state k≥6 such that `waitN` was high at the rising edge that began state k−1.
- R10: In handshake mode, while `waitN` stays low the cycle keeps adding one state per clock, beyond the counter's top value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one period is one bus state |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus cycle request |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| bypass | input | 1 | Region served by another controller; do not sequence |
| rdCode | input | 4 | Wait code for read cycles |
| wrCode | input | 4 | Wait code for write cycles |
| waitN | input | 1 | Asynchronous active-low wait pin |
| busy | output | 1 | High during every state of a running cycle |
| done | output | 1 | One-clock pulse in the final state |
| notServiced | output | 1 | One-clock pulse after a bypassed request |
| cfgError | output | 1 | Sticky flag: a reserved code was used |

## Verification
`busy` rises on the clock right after the accepting edge. `done` falls in the clock where `busy` is last high, and `notServiced` appears one clock after a bypassed request. The bench drives inputs on the falling edge and samples on every falling edge after the accept. It counts busy clocks and records where `done` fell, so each cycle length is measured exactly and not checked in a window. In handshake tests the pin is released in a known state R. That change is first seen at the edge that begins state R+1, so the expected length is max(6, R+2).

// File: rtl/bws_pkg.sv
package bws_pkg;

  typedef struct packed {
    logic start;    // accept a request, latch its code
    logic advance;  // move to the next bus state
    logic isWrite;  // direction of the request being accepted
  } seqStrobe_t;

  typedef struct packed {
    logic       handshake;
    logic       reserved;
    logic [4:0] states;
  } codeInfo_t;

  localparam logic [4:0] DEFAULT_STATES = 5'd3;

  function automatic codeInfo_t decodeCode(input logic [3:0] code);
    codeInfo_t info;
    info.handshake = 1'b0;
    info.reserved  = 1'b0;
    info.states    = DEFAULT_STATES;
    case (code)
      4'b0001: info.states = 5'd2;
      4'b0010: info.states = 5'd3;
      4'b0011: info.handshake = 1'b1;
      4'b0100: info.states = 5'd22;
      4'b0101: info.states = 5'd4;
      4'b0110: info.states = 5'd5;
      4'b0111: info.states = 5'd6;
      4'b1000: info.states = 5'd7;
      4'b1001: info.states = 5'd8;
      4'b1010: info.states = 5'd9;
      4'b1011: info.states = 5'd10;
      4'b1100: info.states = 5'd11;
      4'b1101: info.states = 5'd12;
      4'b1110: info.states = 5'd14;
      4'b1111: info.states = 5'd18;
      default: info.reserved = 1'b1;
    endcase
    return info;
  endfunction

endpackage

// File: rtl/bws_datapath.sv
module bws_datapath
  import bws_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int HS_MIN      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic [3:0] rdCode,
  input  logic [3:0] wrCode,
  input  logic       waitN,
  output logic       lastState,
  output logic       cfgError
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] HS_MIN_C = CNT_W'(HS_MIN);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   waitSeen;
  logic [CNT_W-1:0]       stateCnt;
  logic [CNT_W-1:0]       lenQ;
  logic                   hsQ;
  logic                   errQ;
  logic [3:0]             selCode;
  codeInfo_t              selInfo;

  // Synchronizer for the asynchronous wait pin; a single stage is widened to two.
  generate
    if (SYNC_STAGES >= 2) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], waitN};
      end
    end else begin : g_sync_min
      logic preQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          preQ  <= 1'b1;
          syncQ <= '1;
        end else begin
          preQ  <= waitN;
          syncQ <= preQ;
        end
      end
    end
  endgenerate

  assign waitSeen = syncQ[SYNC_STAGES-1];

  always_comb begin
    selCode = strobe.isWrite ? wrCode : rdCode;
    selInfo = decodeCode(selCode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateCnt <= '0;
      lenQ     <= CNT_W'(DEFAULT_STATES);
      hsQ      <= 1'b0;
      errQ     <= 1'b0;
    end else if (strobe.start) begin
      stateCnt <= CNT_W'(1);
      lenQ     <= CNT_W'(selInfo.states);
      hsQ      <= selInfo.handshake;
      if (selInfo.reserved) errQ <= 1'b1;
    end else if (strobe.advance && stateCnt != CNT_MAX) begin
      stateCnt <= stateCnt + 1'b1;
    end
  end

  // The synchronizer output in state k reflects the pin at the edge that
  // began state k-(SYNC_STAGES-1); this stands in for the sixth-state sample.
  assign lastState = hsQ ? ((stateCnt >= HS_MIN_C) && waitSeen)
                         : (stateCnt == lenQ);
  assign cfgError  = errQ;

  a_r5_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

  a_r3_len_in_range: assert property (@(posedge clk) disable iff (!rstN)
    !hsQ |-> (lenQ >= CNT_W'(2) && lenQ <= CNT_W'(22)));

  a_r10_count_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (stateCnt == CNT_MAX && !strobe.start) |=> stateCnt == CNT_MAX);

endmodule

// File: rtl/bws_ctrl.sv
module bws_ctrl
  import bws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       bypass,
  input  logic       lastState,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       notServiced
);

  typedef enum logic {S_IDLE, S_ACTIVE} ctrlState_t;

  ctrlState_t stateQ;
  logic       nsQ;

  always_comb begin
    strobe.isWrite = reqWrite;
    strobe.start   = (stateQ == S_IDLE) && reqValid && !bypass;
    strobe.advance = (stateQ == S_ACTIVE) && !lastState;
    done           = (stateQ == S_ACTIVE) && lastState;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      nsQ    <= 1'b0;
    end else begin
      nsQ <= (stateQ == S_IDLE) && reqValid && bypass;
      case (stateQ)
        S_IDLE:   if (strobe.start) stateQ <= S_ACTIVE;
        S_ACTIVE: if (lastState)    stateQ <= S_IDLE;
        default:  stateQ <= S_IDLE;
      endcase
    end
  end

  assign busy        = (stateQ == S_ACTIVE);
  assign notServiced = nsQ;

  a_r4_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done));

  a_r7_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  a_r8_bypass_no_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && bypass) |=> (!busy && notServiced));

  a_r8_ns_idle: assert property (@(posedge clk) disable iff (!rstN)
    notServiced |-> !busy);

endmodule

// File: rtl/busWaitSeq.sv
module busWaitSeq
  import bws_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int HS_MIN      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       bypass,
  input  logic [3:0] rdCode,
  input  logic [3:0] wrCode,
  input  logic       waitN,
  output logic       busy,
  output logic       done,
  output logic       notServiced,
  output logic       cfgError
);

  seqStrobe_t strobe;
  logic       lastState;

  bws_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .bypass     (bypass),
    .lastState  (lastState),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .notServiced(notServiced)
  );

  bws_datapath #(
    .CNT_W      (CNT_W),
    .HS_MIN     (HS_MIN),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdCode   (rdCode),
    .wrCode   (wrCode),
    .waitN    (waitN),
    .lastState(lastState),
    .cfgError (cfgError)
  );

endmodule

// File: tb/busWaitSeq_bench.sv
module busWaitSeq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqWrite = 1'b0;
  logic       bypass = 1'b0;
  logic [3:0] rdCode = 4'b0010;
  logic [3:0] wrCode = 4'b0010;
  logic       waitN = 1'b1;
  logic       busy, done, notServiced, cfgError;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  busWaitSeq u_busWaitSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .bypass(bypass), .rdCode(rdCode), .wrCode(wrCode), .waitN(waitN),
    .busy(busy), .done(done), .notServiced(notServiced), .cfgError(cfgError)
  );

  typedef struct packed {
    logic       wr;
    logic [3:0] code;
    logic [4:0] len;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 4'b0001, 5'd2},  '{1'b0, 4'b0010, 5'd3},  '{1'b0, 4'b0100, 5'd22},
    '{1'b0, 4'b0101, 5'd4},  '{1'b0, 4'b0110, 5'd5},  '{1'b0, 4'b0111, 5'd6},
    '{1'b0, 4'b1000, 5'd7},  '{1'b0, 4'b1001, 5'd8},  '{1'b0, 4'b1010, 5'd9},
    '{1'b0, 4'b1011, 5'd10}, '{1'b0, 4'b1100, 5'd11}, '{1'b0, 4'b1101, 5'd12},
    '{1'b0, 4'b1110, 5'd14}, '{1'b0, 4'b1111, 5'd18},
    '{1'b1, 4'b0001, 5'd2},  '{1'b1, 4'b0100, 5'd22}, '{1'b1, 4'b1111, 5'd18},
    '{1'b1, 4'b0110, 5'd5}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Issues one request at a falling edge and measures the resulting cycle.
  // releaseAt>0: raise waitN at the falling edge of that state.
  // chgAt>0: switch both codes to 0001 at the falling edge of that state.
  task automatic runCycle(input logic wr, input int expLen, input int releaseAt,
                          input int chgAt, input string tag);
    int n = 0;
    int doneCnt = 0;
    int doneAt = 0;
    reqWrite = wr;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (busy && n < 200) begin
      n++;
      if (done) begin doneCnt++; doneAt = n; end
      if (releaseAt == n) waitN = 1'b1;
      if (chgAt == n) begin rdCode = 4'b0001; wrCode = 4'b0001; end
      @(negedge clk);
    end
    check(n == expLen, {tag, " length"}, n, expLen);
    check(doneCnt == 1 && doneAt == n, {tag, " done position"}, doneAt, n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check({busy, done, notServiced, cfgError} == 4'b0, "R1 in reset",
          {busy, done, notServiced, cfgError}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, notServiced, cfgError} == 4'b0, "R1 after reset",
          {busy, done, notServiced, cfgError}, 0);

    // R3 / R2 / R4: table walk; the unused code is set to a distinct length
    for (int i = 0; i < NVEC; i++) begin
      rdCode = VEC[i].wr ? 4'b0100 : VEC[i].code;
      wrCode = VEC[i].wr ? VEC[i].code : 4'b0001;
      runCycle(VEC[i].wr, int'(VEC[i].len), 0, 0,
               VEC[i].wr ? "R2 R3 R4 write" : "R2 R3 R4 read");
      @(negedge clk);
    end
    check(cfgError == 1'b0, "R5 no error on valid codes", cfgError, 0);

    // R6: code change mid-cycle ignored
    rdCode = 4'b0100;
    runCycle(1'b0, 22, 0, 3, "R6 read mid change");
    wrCode = 4'b1110;
    runCycle(1'b1, 14, 0, 2, "R6 write mid change");

    // R5: reserved code -> 3 states, sticky error
    rdCode = 4'b0000;
    runCycle(1'b0, 3, 0, 0, "R5 reserved");
    check(cfgError == 1'b1, "R5 error set", cfgError, 1);
    rdCode = 4'b0001;
    runCycle(1'b0, 2, 0, 0, "R5 after reserved");
    check(cfgError == 1'b1, "R5 error sticky", cfgError, 1);

    // R9: handshake mode, wait pin high throughout -> six states
    rdCode = 4'b0011;
    waitN = 1'b1;
    runCycle(1'b0, 6, 0, 0, "R9 pin idle");
    // R9: released in state R -> max(6, R+2)
    waitN = 1'b0; repeat (3) @(negedge clk);
    runCycle(1'b0, 6, 2, 0, "R9 early release");
    waitN = 1'b0; repeat (3) @(negedge clk);
    runCycle(1'b0, 6, 4, 0, "R9 release state 4");
    waitN = 1'b0; repeat (3) @(negedge clk);
    runCycle(1'b0, 7, 5, 0, "R9 release state 5");
    waitN = 1'b0; repeat (3) @(negedge clk);
    wrCode = 4'b0011;
    runCycle(1'b1, 11, 9, 0, "R9 write release state 9");
    // R10: long stretch past counter top
    waitN = 1'b0; repeat (3) @(negedge clk);
    runCycle(1'b0, 42, 40, 0, "R10 long stretch");

    // R7: request held high across cycles
    rdCode = 4'b0001;
    reqWrite = 1'b0;
    reqValid = 1'b1;
    begin
      logic [5:0] seen;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        seen[k] = busy;
        if (k == 5) reqValid = 1'b0;
      end
      check(seen == 6'b011011, "R7 busy pattern", seen, 6'b011011);
    end
    repeat (3) @(negedge clk);

    // R8: bypass
    bypass = 1'b1;
    reqValid = 1'b1;
    @(negedge clk);
    check(notServiced == 1'b1 && busy == 1'b0, "R8 not serviced",
          {notServiced, busy}, 2'b10);
    reqValid = 1'b0;
    @(negedge clk);
    check(notServiced == 1'b0 && busy == 1'b0, "R8 pulse ends",
          {notServiced, busy}, 2'b00);
    bypass = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule